// File: doc/BRIEF.md
# Pin Solder-Joint Fault Monitor

This block watches the solder joints of two spare bidirectional I/O pins that are tied to one shared capacitor on the board. It runs a repeating test. One pin, the driver, drives logic 1 to charge the capacitor. The other pin, the sense pin, reads the capacitor level back. If a joint has cracked and turned highly resistive, the capacitor does not charge within the write window and the readback is 0. That readback is counted as a fault event against the driving pin.

The two pins swap roles on alternate tests, so each joint is charged through separately. After every sample, both pins drive 0 for one cycle to empty the capacitor, so the next test starts from a known low level. For each pin the block keeps three things: a saturating fault counter, a one-cycle live fault pulse and a sticky fault flag. A synchronous clear input resets the counters and the flags. The pad-side outputs (output enable and output value per pin) and the raw pad inputs are brought to ports, so the pad ring can be attached directly, or a bench can model the capacitor.

Top module: `sjm_monitor`

## Requirements
- R1: After reset, pin A (index 0) is the driver first. A driver holds pad_oe_o and pad_out_o high for its bit only, for CHARGE_CYC+1 cycles. Then comes one discharge cycle with pad_oe_o=2'b11 and pad_out_o=2'b00. Then pin B (index 1) takes the driver role in the same way, and the roles keep alternating.
- R2: In the last drive cycle of a test, the block takes the synchronized level of the sense pin. A 0 there is a fault event for the driver, and a 1 is a healthy result.
- R3: If the driving joint cannot charge the capacitor for the whole drive window, a fault is reported in every test that pin drives.
- R4: fault_live_o[p] is high for exactly one cycle, the discharge cycle that follows a faulty test driven by pin p. Otherwise it is low.
- R5: Each fault event adds one to the counter of the faulty pin. The counter stops at 255 and never wraps. fault_cnt_o carries pin A in bits [7:0] and pin B in bits [15:8].
- R6: fault_sticky_o[p] sets on a fault event of pin p and stays set until a clear.
- R7: clr_i high at a clock edge zeroes both counters and both sticky flags at that edge.
- R8: If clr_i and a fault event of pin p fall on the same edge, the fault wins for that pin: its counter becomes 1 and its sticky flag is set. The other pin is cleared.
- R9: During and right after reset, the counters, the sticky flags and the live pulses are all 0.
- R10: Tests in which both joints are healthy never raise a live pulse, never change a counter and never set a sticky flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of the counters and sticky flags |
| pad_in_i | input | 2 | Raw pad input levels, pin A in bit 0 |
| pad_oe_o | output | 2 | Pad output enable per pin |
| pad_out_o | output | 2 | Pad output value per pin |
| fault_live_o | output | 2 | One-cycle fault pulse per pin |
| fault_sticky_o | output | 2 | Sticky fault flag per pin |
| fault_cnt_o | output | 16 | Saturating fault counters, pin A low byte |

## Verification
The assertions assume that pad_in_i may change at any time, because it passes through a synchronizer. They also assume that clr_i is a plain synchronous level. Otherwise they rely only on the outputs of the block itself.

The stimulus models the capacitor as a register. The register follows whichever pin drives it through a healthy joint, and it is read through the synchronizer path. Joint faults are injected or removed only at the start of a pin A drive phase, so every test sees a single fault condition for its whole window. The clear pulse is placed exactly on the sample cycle of a faulty test to exercise the priority case.

// File: rtl/sjm_pkg.sv
package sjm_pkg;

    localparam int NUM_PINS = 2;

    typedef enum logic [1:0] {
        ST_CHARGE = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_DISCH  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/sjm_sync.sv
module sjm_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    generate
        if (STAGES == 0) begin : g_bypass
            assign sync_o = async_i;
        end else begin : g_chain
            logic [WIDTH-1:0] stg_d [STAGES];
            logic [WIDTH-1:0] stg_q [STAGES];

            always_comb begin
                stg_d[0] = async_i;
                for (int i = 1; i < STAGES; i++) begin
                    stg_d[i] = stg_q[i-1];
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < STAGES; i++) begin
                        stg_q[i] <= '0;
                    end
                end else begin
                    for (int i = 0; i < STAGES; i++) begin
                        stg_q[i] <= stg_d[i];
                    end
                end
            end

            assign sync_o = stg_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/sjm_seq.sv
module sjm_seq
    import sjm_pkg::*;
#(
    parameter int CHARGE_CYC = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] sense_i,
    output logic [NUM_PINS-1:0] pad_oe_o,
    output logic [NUM_PINS-1:0] pad_out_o,
    output logic [NUM_PINS-1:0] fault_evt_o
);

    localparam int CW = (CHARGE_CYC > 1) ? $clog2(CHARGE_CYC) : 1;
    localparam logic [CW-1:0] LAST_CHG = CW'(CHARGE_CYC - 1);

    typedef struct packed {
        seq_state_e    st;
        logic          drv;   // 0: pin A drives, 1: pin B drives
        logic [CW-1:0] cnt;
    } seq_reg_t;

    seq_reg_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            ST_CHARGE: begin
                if (seq_q.cnt == LAST_CHG) begin
                    seq_d.st  = ST_SAMPLE;
                    seq_d.cnt = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            ST_SAMPLE: begin
                seq_d.st = ST_DISCH;
            end
            ST_DISCH: begin
                seq_d.st  = ST_CHARGE;
                seq_d.drv = ~seq_q.drv;
            end
            default: begin
                seq_d.st  = ST_CHARGE;
                seq_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_CHARGE, drv: 1'b0, cnt: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    // Pad drive and fault detection follow the registered state only.
    always_comb begin
        pad_oe_o    = '0;
        pad_out_o   = '0;
        fault_evt_o = '0;
        unique case (seq_q.st)
            ST_CHARGE: begin
                pad_oe_o[seq_q.drv]  = 1'b1;
                pad_out_o[seq_q.drv] = 1'b1;
            end
            ST_SAMPLE: begin
                pad_oe_o[seq_q.drv]    = 1'b1;
                pad_out_o[seq_q.drv]   = 1'b1;
                fault_evt_o[seq_q.drv] = ~sense_i[~seq_q.drv];
            end
            ST_DISCH: begin
                pad_oe_o  = '1;
                pad_out_o = '0;
            end
            default: begin
                pad_oe_o = '0;
            end
        endcase
    end

endmodule

// File: rtl/sjm_pin_stat.sv
module sjm_pin_stat #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             evt_i,
    output logic             live_o,
    output logic             sticky_o,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic             live;
        logic             sticky;
        logic [CNT_W-1:0] cnt;
    } stat_reg_t;

    stat_reg_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.live = evt_i;
        if (clr_i) begin
            st_d.cnt    = '0;
            st_d.sticky = 1'b0;
        end
        if (evt_i) begin
            st_d.sticky = 1'b1;
            if (st_d.cnt != CNT_MAX) begin
                st_d.cnt = st_d.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign live_o   = st_q.live;
    assign sticky_o = st_q.sticky;
    assign cnt_o    = st_q.cnt;

endmodule

// File: rtl/sjm_monitor.sv
module sjm_monitor
    import sjm_pkg::*;
#(
    parameter int CHARGE_CYC  = 4,
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr_i,
    input  logic [NUM_PINS-1:0]       pad_in_i,
    output logic [NUM_PINS-1:0]       pad_oe_o,
    output logic [NUM_PINS-1:0]       pad_out_o,
    output logic [NUM_PINS-1:0]       fault_live_o,
    output logic [NUM_PINS-1:0]       fault_sticky_o,
    output logic [NUM_PINS*CNT_W-1:0] fault_cnt_o
);

    logic [NUM_PINS-1:0] sense_sync;
    logic [NUM_PINS-1:0] fault_evt;

    sjm_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (NUM_PINS)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pad_in_i),
        .sync_o  (sense_sync)
    );

    sjm_seq #(
        .CHARGE_CYC (CHARGE_CYC)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .sense_i     (sense_sync),
        .pad_oe_o    (pad_oe_o),
        .pad_out_o   (pad_out_o),
        .fault_evt_o (fault_evt)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        sjm_pin_stat #(
            .CNT_W (CNT_W)
        ) u_stat (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr_i    (clr_i),
            .evt_i    (fault_evt[p]),
            .live_o   (fault_live_o[p]),
            .sticky_o (fault_sticky_o[p]),
            .cnt_o    (fault_cnt_o[p*CNT_W +: CNT_W])
        );
    end

endmodule

// File: rtl/sjm_monitor_chk.sv
module sjm_monitor_chk #(
    parameter int CNT_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               clr_i,
    input logic [1:0]         pad_oe_o,
    input logic [1:0]         pad_out_o,
    input logic [1:0]         fault_live_o,
    input logic [1:0]         fault_sticky_o,
    input logic [2*CNT_W-1:0] fault_cnt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // R1
    one_driver_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pad_oe_o & pad_out_o) && ((pad_out_o & ~pad_oe_o) == 2'b00));

    // R4
    live_in_discharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_live_o != 2'b00) |-> (pad_oe_o == 2'b11 && pad_out_o == 2'b00));

    // R4
    live_single_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fault_live_o));

    for (genvar p = 0; p < 2; p++) begin : g_pin
        // R5
        cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (fault_live_o[p] && !$past(clr_i) && $past(fault_cnt_o[p*CNT_W +: CNT_W]) != CNT_MAX)
            |-> fault_cnt_o[p*CNT_W +: CNT_W] == $past(fault_cnt_o[p*CNT_W +: CNT_W]) + 1'b1);

        // R5
        no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(clr_i) |-> fault_cnt_o[p*CNT_W +: CNT_W] >= $past(fault_cnt_o[p*CNT_W +: CNT_W]));

        // R6
        sticky_follows_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
            fault_live_o[p] |-> fault_sticky_o[p]);

        // R6
        sticky_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(fault_sticky_o[p]) && !$past(clr_i)) |-> fault_sticky_o[p]);

        // R7
        clear_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(clr_i) && !fault_live_o[p])
            |-> (fault_cnt_o[p*CNT_W +: CNT_W] == '0 && !fault_sticky_o[p]));

        // R8
        clear_with_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(clr_i) && fault_live_o[p])
            |-> (fault_cnt_o[p*CNT_W +: CNT_W] == CNT_W'(1) && fault_sticky_o[p]));
    end

endmodule

bind sjm_monitor sjm_monitor_chk #(
    .CNT_W (CNT_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .clr_i          (clr_i),
    .pad_oe_o       (pad_oe_o),
    .pad_out_o      (pad_out_o),
    .fault_live_o   (fault_live_o),
    .fault_sticky_o (fault_sticky_o),
    .fault_cnt_o    (fault_cnt_o)
);

// File: tb/sjm_monitor_tb.sv
module sjm_monitor_tb;

    localparam int CHARGE_CYC = 4;
    localparam int CNT_W      = 8;
    localparam int NVEC       = 5;

    // vector: {inject A, inject B, rounds[7:0]}
    localparam logic [9:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 8'd3},
        {1'b1, 1'b0, 8'd2},
        {1'b0, 1'b1, 8'd3},
        {1'b1, 1'b1, 8'd2},
        {1'b0, 1'b0, 8'd2}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             clr = 1'b0;
    logic [1:0]       pad_in;
    logic [1:0]       pad_oe, pad_out, live, sticky;
    logic [2*CNT_W-1:0] cnt;
    logic             inj_a = 1'b0, inj_b = 1'b0;
    logic             cap = 1'b0;
    int               checks = 0, errors = 0;
    int               exp_a = 0, exp_b = 0;
    logic             exp_sa = 1'b0, exp_sb = 1'b0;

    always #10 clk = ~clk;

    // Capacitor model: follows a pin that drives through a healthy joint.
    always @(posedge clk) begin
        if (pad_oe[0] && !inj_a)      cap <= pad_out[0];
        else if (pad_oe[1] && !inj_b) cap <= pad_out[1];
    end
    assign pad_in = {cap, cap};

    sjm_monitor #(
        .CHARGE_CYC  (CHARGE_CYC),
        .SYNC_STAGES (2),
        .CNT_W       (CNT_W)
    ) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .clr_i          (clr),
        .pad_in_i       (pad_in),
        .pad_oe_o       (pad_oe),
        .pad_out_o      (pad_out),
        .fault_live_o   (live),
        .fault_sticky_o (sticky),
        .fault_cnt_o    (cnt)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_round();
        logic [1:0] prev;
        do begin
            prev = pad_oe;
            @(negedge clk);
        end while (!(pad_oe == 2'b01 && prev == 2'b11));
    endtask

    task automatic run_rounds(input int n);
        for (int i = 0; i < n; i++) wait_round();
    endtask

    task automatic check_status(input string req);
        check({req, " cnt A"}, int'(cnt[CNT_W-1:0]), exp_a);
        check({req, " cnt B"}, int'(cnt[2*CNT_W-1:CNT_W]), exp_b);
        check({req, " sticky A"}, int'(sticky[0]), int'(exp_sa));
        check({req, " sticky B"}, int'(sticky[1]), int'(exp_sb));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 cnt", int'(cnt), 0);
        check("R9 sticky", int'(sticky), 0);
        check("R9 live", int'(live), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 first driver A oe", int'(pad_oe), 1);

        wait_round();
        // R1 alternation and drive pattern
        check("R1 A drive out", int'(pad_out), 1);
        repeat (CHARGE_CYC + 1) @(negedge clk);
        check("R1 discharge oe", int'(pad_oe), 3);
        check("R1 discharge out", int'(pad_out), 0);
        @(negedge clk);
        check("R1 B drive oe", int'(pad_oe), 2);
        check("R1 B drive out", int'(pad_out), 2);

        // Vector table: R2 R3 R5 R6 R10
        wait_round();
        for (int v = 0; v < NVEC; v++) begin
            inj_a = VEC[v][9];
            inj_b = VEC[v][8];
            n     = int'(VEC[v][7:0]);
            run_rounds(n);
            if (VEC[v][9]) begin exp_a += n; exp_sa = 1'b1; end
            if (VEC[v][8]) begin exp_b += n; exp_sb = 1'b1; end
            check_status("R2 R3 R10 vector");
        end

        // R4 live pulse timing on a pin A fault
        inj_a = 1'b1; inj_b = 1'b0;
        repeat (CHARGE_CYC) @(negedge clk);
        check("R4 live before sample", int'(live), 0);
        @(negedge clk);
        check("R4 live in discharge", int'(live), 1);
        @(negedge clk);
        check("R4 live one cycle", int'(live), 0);
        wait_round();
        exp_a += 1;
        check_status("R4 R5 after pulse");

        // R5 saturation
        run_rounds(260);
        exp_a = 255;
        check_status("R5 saturate");
        run_rounds(2);
        check("R5 no wrap", int'(cnt[CNT_W-1:0]), 255);

        // R7 clear with no fault in flight
        inj_a = 1'b0;
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        exp_a = 0; exp_b = 0; exp_sa = 1'b0; exp_sb = 1'b0;
        check_status("R7 clear");
        wait_round();

        // R8 clear coinciding with a pin A fault
        inj_a = 1'b1; inj_b = 1'b1;
        wait_round();
        check("R8 pre cnt B", int'(cnt[2*CNT_W-1:CNT_W]), 1);
        inj_a = 1'b1; inj_b = 1'b0;
        repeat (CHARGE_CYC) @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        exp_a = 1; exp_b = 0; exp_sa = 1'b1; exp_sb = 1'b0;
        check_status("R8 clear vs fault");
        check("R8 live A", int'(live), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule